// File: doc/BRIEF.md
# Reset Source and Start-up Controller

This block gathers every reset request of a small microcontroller core and turns it into one of two reset outputs. A cold reset (`chip_rst_o`) reinitialises the whole core: program counter to zero, interrupts masked, prescaler and watchdog cleared, ports set to input, and the timer/event counter stopped. A warm reset (`warm_rst_o`) reaches only the program counter and stack pointer. The three sources are a power-on detect (`por_n_i`), an active-low external reset pin, and a single-cycle watchdog time-out strobe. The block also tracks whether the core is running or halted in power-down. A halt-entry strobe from the core moves it into the halted state.

The reset path runs through a start-up timer of `SST_BITS` bits. A cause that is still present holds the timer at zero. Once the cause is gone, the timer counts 2^SST_BITS rising clock edges and then releases the reset, so the oscillator has time to settle. The default is 10 bits, which gives 1024 cycles. A watchdog time-out while halted starts a warm reset and leaves every other piece of state alone. Every other cause starts a cold reset.

Two status flags record the last cause for firmware: a time-out flag and a power-down flag. Each cause writes its own pattern into them.

Top module: `reset_start_ctrl`

## Requirements
- R1: While `por_n_i` is low, the outputs are `chip_rst_o`=1, `warm_rst_o`=0, `to_flag_o`=0, `pdf_flag_o`=0 and `halted_o`=0. After `por_n_i` returns high, `chip_rst_o` falls at the 2^SST_BITS-th rising edge.
- R2: The external pin passes through a two-flop synchronizer. The first two rising edges after the pin falls do not yet start a reset. The reset is active from the third edge and stays active while the pin is low. After the pin returns high, the reset output falls at the (2^SST_BITS+2)-th rising edge.
- R3: If the pin is asserted while the core is running (not halted), a cold reset occurs and both flags keep their values.
- R4: If the pin is asserted while halted, a cold reset occurs, `to_flag_o` becomes 0, `pdf_flag_o` becomes 1, and `halted_o` clears.
- R5: If the watchdog strobes while the core is running, a cold reset starts at that edge and lasts exactly 2^SST_BITS cycles. `to_flag_o` becomes 1 and `pdf_flag_o` is unchanged.
- R6: If the watchdog strobes while halted, the controller gives a warm reset instead. `warm_rst_o` is high for exactly 2^SST_BITS cycles and `chip_rst_o` stays 0 throughout. Both flags become 1 and `halted_o` clears.
- R7: If `halt_req_i` arrives while running with no reset active, `halted_o` is set at the next edge. If it arrives while either reset output is high, it is ignored.
- R8: A new cause that arrives while the start-up timer is running restarts the count from zero. The flags and the reset kind then follow the newest cause. A watchdog strobe during a warm start-up therefore turns it into a cold reset.
- R9: `chip_rst_o` and `warm_rst_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System (oscillator) clock |
| por_n_i | input | 1 | Power-on detect, asynchronous, active low |
| ext_rst_n_i | input | 1 | External reset pin, asynchronous, active low |
| wdt_tmo_i | input | 1 | Watchdog time-out strobe, one cycle, synchronous |
| halt_req_i | input | 1 | Halt-entry strobe from the core, synchronous |
| chip_rst_o | output | 1 | Cold (full) reset to the core, active high |
| warm_rst_o | output | 1 | Warm reset to program counter and stack pointer, active high |
| to_flag_o | output | 1 | Time-out status flag |
| pdf_flag_o | output | 1 | Power-down status flag |
| halted_o | output | 1 | Core is in power-down |

## Verification
The bench builds the controller with `SST_BITS` = 4, so each start-up window lasts 16 cycles. With windows that short, the bench can sweep every pairing of cause (pin or watchdog), core state (running or halted) and starting power-down flag, and time every release edge exactly. It also covers the two-edge synchronizer delay, a restart in the middle of a count, a warm start-up promoted to cold, and halt requests made during reset. For each of these it computes the expected flags and window lengths arithmetically.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_PIN  = 2'd1,
    CAUSE_WDT  = 2'd2
  } cause_e;

  typedef enum logic {
    KIND_COLD = 1'b0,
    KIND_WARM = 1'b1
  } rst_kind_e;

  typedef struct packed {
    logic to;
    logic pdf;
  } flags_t;

  // Status flag update for one reset cause, given the power-down state
  function automatic flags_t next_flags(cause_e c, logic halted, flags_t cur);
    flags_t f;
    f = cur;
    case (c)
      CAUSE_PIN: begin
        if (halted) begin
          f.to  = 1'b0;
          f.pdf = 1'b1;
        end
      end
      CAUSE_WDT: begin
        f.to = 1'b1;
        if (halted) f.pdf = 1'b1;
      end
      default: f = cur;
    endcase
    return f;
  endfunction

  // Only a watchdog expiry in power-down is served by the warm path
  function automatic rst_kind_e kind_of(cause_e c, logic halted);
    return (c == CAUSE_WDT && halted) ? KIND_WARM : KIND_COLD;
  endfunction

endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int  STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) chain_q <= {STAGES{RST_VAL}};
    else           chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsc_cause.sv
module rsc_cause
  import rsc_pkg::*;
(
  input  logic   pin_act_i,
  input  logic   wdt_tmo_i,
  input  logic   halt_req_i,
  input  logic   busy_i,
  input  logic   halted_i,
  output cause_e cause_o,
  output logic   start_o,
  output logic   halt_ok_o
);
  // Pin wins over the watchdog when both are seen in the same cycle
  always_comb begin
    if (pin_act_i)      cause_o = CAUSE_PIN;
    else if (wdt_tmo_i) cause_o = CAUSE_WDT;
    else                cause_o = CAUSE_NONE;
  end

  assign start_o   = (cause_o != CAUSE_NONE);
  assign halt_ok_o = halt_req_i && !busy_i && !halted_i && !start_o;
endmodule

// File: rtl/rsc_sst.sv
module rsc_sst #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         arst_n_i,
  input  logic         restart_i,
  output logic         busy_o,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] LAST = {W{1'b1}};

  function automatic logic at_last(logic [W-1:0] c);
    return c == LAST;
  endfunction

  logic         busy_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (restart_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (at_last(cnt_q)) busy_q <= 1'b0;
      else                cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/reset_start_ctrl.sv
module reset_start_ctrl
  import rsc_pkg::*;
#(
  parameter int SST_BITS    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic ext_rst_n_i,
  input  logic wdt_tmo_i,
  input  logic halt_req_i,
  output logic chip_rst_o,
  output logic warm_rst_o,
  output logic to_flag_o,
  output logic pdf_flag_o,
  output logic halted_o
);
  // Named internal events, visible to the checker
  logic                pin_sync_w;
  logic                pin_act_w;
  cause_e              cause_w;
  logic                start_ev_w;
  logic                halt_ok_w;
  logic                sst_busy_w;
  logic [SST_BITS-1:0] sst_cnt_w;

  flags_t    flags_q;
  logic      halted_q;
  rst_kind_e kind_q;

  rsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk_i    (clk_i),
    .arst_n_i (por_n_i),
    .d_i      (ext_rst_n_i),
    .q_o      (pin_sync_w)
  );

  assign pin_act_w = !pin_sync_w;

  rsc_cause u_cause (
    .pin_act_i  (pin_act_w),
    .wdt_tmo_i  (wdt_tmo_i),
    .halt_req_i (halt_req_i),
    .busy_i     (sst_busy_w),
    .halted_i   (halted_q),
    .cause_o    (cause_w),
    .start_o    (start_ev_w),
    .halt_ok_o  (halt_ok_w)
  );

  rsc_sst #(.W(SST_BITS)) u_sst (
    .clk_i     (clk_i),
    .arst_n_i  (por_n_i),
    .restart_i (start_ev_w),
    .busy_o    (sst_busy_w),
    .cnt_o     (sst_cnt_w)
  );

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      flags_q  <= '0;
      halted_q <= 1'b0;
      kind_q   <= KIND_COLD;
    end else begin
      if (start_ev_w) begin
        flags_q  <= next_flags(cause_w, halted_q, flags_q);
        kind_q   <= kind_of(cause_w, halted_q);
        halted_q <= 1'b0;
      end else if (halt_ok_w) begin
        halted_q <= 1'b1;
      end
    end
  end

  assign chip_rst_o = sst_busy_w && (kind_q == KIND_COLD);
  assign warm_rst_o = sst_busy_w && (kind_q == KIND_WARM);
  assign to_flag_o  = flags_q.to;
  assign pdf_flag_o = flags_q.pdf;
  assign halted_o   = halted_q;
endmodule

// File: rtl/reset_start_ctrl_checker.sv
module reset_start_ctrl_checker #(
  parameter int SST_BITS = 10
) (
  input logic                clk_i,
  input logic                por_n_i,
  input logic                wdt_tmo_i,
  input logic                halt_req_i,
  input logic                chip_rst_o,
  input logic                warm_rst_o,
  input logic                to_flag_o,
  input logic                pdf_flag_o,
  input logic                halted_o,
  input logic                pin_act_w,
  input logic                start_ev_w,
  input logic                sst_busy_w,
  input logic [SST_BITS-1:0] sst_cnt_w
);
  a_r9_one_kind: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !(chip_rst_o && warm_rst_o));

  a_r3_pin_run_keeps_flags: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (pin_act_w && !halted_o) |=>
      (to_flag_o == $past(to_flag_o)) && (pdf_flag_o == $past(pdf_flag_o)) && chip_rst_o);

  a_r4_pin_wake: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (pin_act_w && halted_o) |=> !to_flag_o && pdf_flag_o && !halted_o && chip_rst_o);

  a_r5_wdt_run: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (!pin_act_w && wdt_tmo_i && !halted_o) |=>
      to_flag_o && (pdf_flag_o == $past(pdf_flag_o)) && chip_rst_o && !warm_rst_o);

  a_r6_wdt_wake: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (!pin_act_w && wdt_tmo_i && halted_o) |=>
      to_flag_o && pdf_flag_o && warm_rst_o && !chip_rst_o && !halted_o);

  a_r7_halt_entry: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (halt_req_i && !wdt_tmo_i && !pin_act_w && !chip_rst_o && !warm_rst_o && !halted_o)
      |=> halted_o);

  a_r7_halt_ignored_in_reset: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (chip_rst_o || warm_rst_o) |=> !halted_o);

  a_r8_restart: assert property (@(posedge clk_i) disable iff (!por_n_i)
    start_ev_w |=> sst_busy_w && (sst_cnt_w == '0));

  a_r1_release_at_end: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $fell(sst_busy_w) |-> ($past(sst_cnt_w) == {SST_BITS{1'b1}}));
endmodule

bind reset_start_ctrl reset_start_ctrl_checker #(.SST_BITS(SST_BITS)) u_checker (
  .clk_i      (clk_i),
  .por_n_i    (por_n_i),
  .wdt_tmo_i  (wdt_tmo_i),
  .halt_req_i (halt_req_i),
  .chip_rst_o (chip_rst_o),
  .warm_rst_o (warm_rst_o),
  .to_flag_o  (to_flag_o),
  .pdf_flag_o (pdf_flag_o),
  .halted_o   (halted_o),
  .pin_act_w  (pin_act_w),
  .start_ev_w (start_ev_w),
  .sst_busy_w (sst_busy_w),
  .sst_cnt_w  (sst_cnt_w)
);

// File: tb/reset_start_ctrl_bench.sv
module reset_start_ctrl_bench;
  localparam int SST_BITS = 4;
  localparam int WIN      = 1 << SST_BITS;

  logic clk = 1'b0;
  logic por_n = 1'b0, ext_n = 1'b1, wdt = 1'b0, halt = 1'b0;
  logic chip, warm, to_f, pdf_f, halted;
  int   checks = 0, errors = 0;
  bit   exp_to = 1'b0, exp_pdf = 1'b0;

  always #10 clk = ~clk;

  reset_start_ctrl #(.SST_BITS(SST_BITS)) u_reset_start_ctrl (
    .clk_i(clk), .por_n_i(por_n), .ext_rst_n_i(ext_n), .wdt_tmo_i(wdt),
    .halt_req_i(halt), .chip_rst_o(chip), .warm_rst_o(warm),
    .to_flag_o(to_f), .pdf_flag_o(pdf_f), .halted_o(halted)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_flags(input string req);
    check(req, "to flag", int'(to_f), int'(exp_to));
    check(req, "pdf flag", int'(pdf_f), int'(exp_pdf));
  endtask

  // Count ticks until the selected reset output is low; the other must stay low
  task automatic measure(input string req, input bit sel_warm, input int exp);
    int n = 0;
    int other = 0;
    while ((sel_warm ? warm : chip) && n < 1000) begin
      tick(1);
      n++;
      if (sel_warm ? chip : warm) other++;
    end
    check(req, "window length", n, exp);
    check("R9", "other reset high cycles", other, 0);
  endtask

  task automatic power_on();
    por_n = 1'b0;
    tick(3);
    check("R1", "chip in por", int'(chip), 1);
    check("R1", "warm in por", int'(warm), 0);
    check("R1", "halted in por", int'(halted), 0);
    exp_to = 1'b0; exp_pdf = 1'b0;
    check_flags("R1");
    por_n = 1'b1;
    measure("R1", 1'b0, WIN);
  endtask

  task automatic enter_halt();
    halt = 1'b1; tick(1); halt = 1'b0;
    check("R7", "halted after request", int'(halted), 1);
  endtask

  task automatic pin_reset(input bit was_halted);
    ext_n = 1'b0;
    tick(2);
    check("R2", "no reset before sync", int'(chip), 0);
    tick(1);
    check("R2", "reset after sync", int'(chip), 1);
    if (was_halted) begin exp_to = 1'b0; exp_pdf = 1'b1; end
    check_flags(was_halted ? "R4" : "R3");
    check(was_halted ? "R4" : "R3", "halted cleared", int'(halted), 0);
    tick(3);
    ext_n = 1'b1;
    measure("R2", 1'b0, WIN + 2);
  endtask

  task automatic wdt_reset(input bit was_halted);
    wdt = 1'b1; tick(1); wdt = 1'b0;
    exp_to = 1'b1;
    if (was_halted) exp_pdf = 1'b1;
    check(was_halted ? "R6" : "R5", "chip level", int'(chip), was_halted ? 0 : 1);
    check(was_halted ? "R6" : "R5", "warm level", int'(warm), was_halted ? 1 : 0);
    check(was_halted ? "R6" : "R5", "halted cleared", int'(halted), 0);
    check_flags(was_halted ? "R6" : "R5");
    measure(was_halted ? "R6" : "R5", was_halted, WIN);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    // Sweep: starting pdf x cause x running/halted
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 2; c++) begin
        for (int h = 0; h < 2; h++) begin
          power_on();
          if (p == 1) begin
            enter_halt();
            pin_reset(1'b1);
          end
          tick(2);
          if (h == 1) enter_halt();
          else check("R7", "still running", int'(halted), 0);
          if (c == 0) pin_reset(h == 1);
          else        wdt_reset(h == 1);
          tick(2);
          check_flags("R8");
        end
      end
    end

    // R8: restart of a cold count by a second watchdog strobe
    power_on();
    wdt = 1'b1; tick(1); wdt = 1'b0;
    tick(5);
    wdt = 1'b1; tick(1); wdt = 1'b0;
    exp_to = 1'b1;
    check_flags("R8");
    measure("R8", 1'b0, WIN);

    // R8: warm start-up promoted to cold by a watchdog strobe
    enter_halt();
    wdt = 1'b1; tick(1); wdt = 1'b0;
    exp_pdf = 1'b1;
    check("R6", "warm started", int'(warm), 1);
    tick(3);
    wdt = 1'b1; tick(1); wdt = 1'b0;
    check("R8", "promoted to cold", int'(chip), 1);
    check("R8", "warm dropped", int'(warm), 0);
    check_flags("R8");
    measure("R8", 1'b0, WIN);

    // R7: halt requests during a cold and a warm window are ignored
    wdt = 1'b1; tick(1); wdt = 1'b0;
    tick(2);
    halt = 1'b1; tick(1); halt = 1'b0;
    check("R7", "halt ignored in cold reset", int'(halted), 0);
    measure("R5", 1'b0, WIN - 3);
    check("R7", "halted after cold window", int'(halted), 0);
    enter_halt();
    wdt = 1'b1; tick(1); wdt = 1'b0;
    halt = 1'b1; tick(1); halt = 1'b0;
    check("R7", "halt ignored in warm reset", int'(halted), 0);
    measure("R6", 1'b1, WIN - 1);
    check("R7", "halted after warm window", int'(halted), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule